// File: doc/BRIEF.md
# Rotating Word-Access Scan Chain

This block is one long scan chain of 512 bits by default. Its first 64 bits form a window that an access port can write or read as a whole word. The other 448 bits form a body that the window can reach only by shifting one bit per cycle. Bits form a ring: the window's top bit feeds the body, and the last bit of the body feeds back into the bottom of the window. Each accepted access starts a background burst of one-bit shifts, one shift per bit of the word, so the ring turns by exactly one word.

After a write, the burst pushes the new word one slot deeper into the body. After a read, the burst brings the next word of the ring into the window. The ring turns by one word for every access. Eight writes therefore lay down a full pattern. The eight reads that follow return the words in the order they were written and leave the ring as it was. A counter tracks which word of the pattern the window holds.

The requester is expected to interleave accesses to many such chains, so that each burst completes before it returns to this one. The request side is a valid/ready port, but it does not apply back-pressure in the usual sense. While `req_ready` is low, a request is not held. It is dropped, and a sticky overrun flag is set. The read result comes out as a one-cycle `rd_valid` pulse with no ready signal, so the consumer must take it in that cycle.

Top module: `ring_scan_chain`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `frame_done` and `overrun_err` are 0, `req_ready` is 1, `word_idx` is 0, and every bit of the ring is 0, so a first read returns zero.
- R2: An access is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle, `busy` stays 1 for exactly WORD_W (64) cycles. `req_ready` is always the inverse of `busy`.
- R3: Suppose the ring holds words S0 (window) through S7 (deepest body slot), and a write of W is accepted. After the burst, the ring holds W in slot 1 and each old Sk in slot k+1. The old S7 wraps into the window, and the old S0 is lost.
- R4: When a read (`req_write`=0) is accepted, `rd_valid` is 1 for exactly the next cycle, with `rd_data` equal to the window word at acceptance. The burst then rotates the ring by one word, with slot 7 moving into the window. An accepted write never raises `rd_valid`.
- R5: Eight consecutive writes of W0..W7 followed by eight reads return W0..W7 in that order. A further eight reads return the same sequence again.
- R6: `word_idx` advances by one, modulo NUM_WORDS, on each accepted access. `frame_done` is 1 for exactly the cycle after the access that wraps `word_idx` from NUM_WORDS-1 to 0.
- R7: A request made while `busy` is 1 is ignored. It does not change the ring contents, `word_idx` or `rd_valid`, and it does not lengthen the current burst. From the following cycle, it sets `overrun_err`.
- R8: `overrun_err` stays 1 through any later accesses and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request can be accepted this cycle (not busy) |
| req_write | input | 1 | 1 = write word into window, 0 = read window |
| req_wdata | input | WORD_W | Word written on an accepted write |
| rd_valid | output | 1 | One-cycle pulse carrying read data |
| rd_data | output | WORD_W | Window word captured at read acceptance |
| busy | output | 1 | Shift burst in progress |
| word_idx | output | clog2(NUM_WORDS) | Pattern slot currently in the window |
| frame_done | output | 1 | Pulse after the access completing a full pattern |
| overrun_err | output | 1 | Sticky: a request arrived while busy |

## Verification
The hardest situation to reach is an overrun in the middle of a burst. A request must land while the chain is still shifting, and the bench must then show three things from outside: nothing was written, no read pulse appeared, and the burst did not restart or stretch. The bench waits a few cycles into a burst and drives one illegal write and then one illegal read. It counts the busy cycles around them, then drains the whole ring with eight reads against its reference model, which shows that the illegal write left no trace. Random mixes of reads and writes then test the wrap of the tail word into the window against the same word-rotation model.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rsc_seq.sv
module rsc_seq
  import rsc_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 8,
  localparam int CNT_W    = bits_for(WORD_W),
  localparam int IDX_W    = bits_for(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  output logic             load_en,
  output logic             cap_en,
  output logic             shift_en,
  output logic             busy,
  output logic [IDX_W-1:0] word_idx,
  output logic             frame_done,
  output logic             overrun_err
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             err_q;
  logic             accept;
  acc_kind_e        kind;

  assign kind     = acc_kind_e'(req_write);
  assign accept   = req_valid && !busy_q;
  assign load_en  = accept && (kind == ACC_WRITE);
  assign cap_en   = accept && (kind == ACC_READ);
  assign shift_en = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      done_q <= (idx_q == IDX_LAST);
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == CNT_LAST) busy_q <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     err_q <= 1'b0;
    else if (req_valid && busy_q) err_q <= 1'b1;
  end

  assign req_ready   = !busy_q;
  assign busy        = busy_q;
  assign word_idx    = idx_q;
  assign frame_done  = done_q;
  assign overrun_err = err_q;

  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(req_valid)); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (idx_q != $past(idx_q)) |-> ($past(req_valid) && !$past(busy_q))); // R6

  AST_DONE_WRAP: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (idx_q == '0)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(err_q) |-> err_q); // R8

endmodule

// File: rtl/rsc_window.sv
module rsc_window #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  input  logic              cap_en,
  input  logic              shift_en,
  input  logic              wrap_bit,
  output logic              feed_bit,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] win_q;
  logic [WORD_W-1:0] rd_q;
  logic              rdv_q;

  always_ff @(posedge clk) begin
    if (rst)           win_q <= '0;
    else if (load_en)  win_q <= load_word;
    else if (shift_en) win_q <= {win_q[WORD_W-2:0], wrap_bit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdv_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      rdv_q <= cap_en;
      if (cap_en) rd_q <= win_q;
    end
  end

  assign feed_bit = win_q[WORD_W-1];
  assign rd_valid = rdv_q;
  assign rd_data  = rd_q;

  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !shift_en) |=> $stable(win_q)); // R7

  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdv_q |=> !rdv_q); // R4

  AST_LOAD_NOT_SHIFT: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !shift_en); // R7

endmodule

// File: rtl/rsc_body.sv
module rsc_body #(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 8,
  localparam int NUM_SEG  = NUM_WORDS - 1
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic feed_bit,
  output logic tail_bit
);

  logic [NUM_SEG-1:0][WORD_W-1:0] seg_q;
  logic [NUM_SEG-1:0]             seg_in;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    if (s == 0) begin : g_head
      assign seg_in[s] = feed_bit;
    end else begin : g_link
      assign seg_in[s] = seg_q[s-1][WORD_W-1];
    end

    always_ff @(posedge clk) begin
      if (rst)           seg_q[s] <= '0;
      else if (shift_en) seg_q[s] <= {seg_q[s][WORD_W-2:0], seg_in[s]};
    end
  end

  assign tail_bit = seg_q[NUM_SEG-1][WORD_W-1];

  AST_BODY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(seg_q)); // R7

endmodule

// File: rtl/ring_scan_chain.sv
module ring_scan_chain
  import rsc_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 8,
  localparam int IDX_W    = bits_for(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic [IDX_W-1:0]  word_idx,
  output logic              frame_done,
  output logic              overrun_err
);

  logic load_en;
  logic cap_en;
  logic shift_en;
  logic feed_bit;
  logic tail_bit;

  rsc_seq #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_ready   (req_ready),
    .load_en     (load_en),
    .cap_en      (cap_en),
    .shift_en    (shift_en),
    .busy        (busy),
    .word_idx    (word_idx),
    .frame_done  (frame_done),
    .overrun_err (overrun_err)
  );

  rsc_window #(.WORD_W(WORD_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_word (req_wdata),
    .cap_en    (cap_en),
    .shift_en  (shift_en),
    .wrap_bit  (tail_bit),
    .feed_bit  (feed_bit),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  rsc_body #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_body (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .feed_bit (feed_bit),
    .tail_bit (tail_bit)
  );

  AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(req_valid) && !$past(req_write) && $past(req_ready))); // R4

endmodule

// File: tb/tb_ring_scan_chain.sv
module tb_ring_scan_chain;

  localparam int W  = 64;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [W-1:0]  req_wdata;
  logic          rd_valid;
  logic [W-1:0]  rd_data;
  logic          busy;
  logic [2:0]    word_idx;
  logic          frame_done;
  logic          overrun_err;

  always #5 clk = ~clk;

  ring_scan_chain #(.WORD_W(W), .NUM_WORDS(NW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .word_idx(word_idx),
    .frame_done(frame_done), .overrun_err(overrun_err)
  );

  int          n_checks = 0;
  int          n_fails  = 0;
  bit          finished = 0;
  logic [W-1:0] ring [NW];
  int          exp_idx;
  logic [W-1:0] last_rd;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int j);
    return {32'hC0DE_0000 + 32'(j), ~(32'h0000_1000 + 32'(j))};
  endfunction

  task automatic model_rotate();
    logic [W-1:0] t;
    t = ring[NW-1];
    for (int k = NW-1; k > 0; k--) ring[k] = ring[k-1];
    ring[0] = t;
  endtask

  task automatic model_clear();
    for (int k = 0; k < NW; k++) ring[k] = '0;
    exp_idx = 0;
  endtask

  task automatic access(input bit wr, input logic [W-1:0] d, input string tag);
    int n;
    bit wrap;
    int guard;
    guard = 0;
    while (!req_ready && guard < 300) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    wrap = (exp_idx == NW-1);
    exp_idx = wrap ? 0 : exp_idx + 1;
    chk(rd_valid == !wr, "R4 rd_valid pulse", W'(rd_valid), W'(!wr));
    if (!wr) begin
      chk(rd_data == ring[0], tag, rd_data, ring[0]);
      last_rd = rd_data;
    end
    chk(word_idx == 3'(exp_idx), "R6 word_idx", W'(word_idx), W'(exp_idx));
    chk(frame_done == wrap, "R6 frame_done", W'(frame_done), W'(wrap));
    if (wr) ring[0] = d;
    model_rotate();
    n = 0;
    while (busy && n < 200) begin n++; @(negedge clk); end
    chk(n == W, "R2 busy length", W'(n), W'(W));
  endtask

  task automatic step(inout int n);
    @(negedge clk);
    if (busy) n++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL R2 watchdog: actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    int n;
    logic [W-1:0] wv;
    seed_init = $urandom(32'd4242);
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    last_rd = '1;
    model_clear();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", W'(busy), 0);
    chk(req_ready == 1'b1, "R1 ready", W'(req_ready), 1);
    chk(overrun_err == 1'b0, "R1 overrun_err", W'(overrun_err), 0);
    chk(word_idx == 3'd0, "R1 word_idx", W'(word_idx), 0);
    chk(rd_valid == 1'b0 && frame_done == 1'b0, "R1 pulses", W'({rd_valid, frame_done}), 0);
    access(1'b0, '0, "R4 read after reset");
    chk(last_rd == '0, "R1 ring zero", last_rd, '0);
    for (int j = 1; j < NW; j++) access(1'b0, '0, "R4 read zero ring");

    // R5 directed pattern: eight writes then two rounds of eight reads
    for (int j = 0; j < NW; j++) access(1'b1, pat(j), "R3 write");
    for (int r = 0; r < 2; r++)
      for (int j = 0; j < NW; j++) begin
        access(1'b0, '0, "R4 read data");
        chk(last_rd == pat(j), "R5 read order", last_rd, pat(j));
      end

    // R7 overrun during a burst
    wv = 64'hDEAD_BEEF_0123_4567;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wdata = wv;
    @(negedge clk);
    req_valid = 1'b0;
    exp_idx = (exp_idx == NW-1) ? 0 : exp_idx + 1;
    ring[0] = wv; model_rotate();
    n = busy ? 1 : 0;
    repeat (10) step(n);
    chk(overrun_err == 1'b0, "R7 no error before overrun", W'(overrun_err), 0);
    req_valid = 1'b1; req_write = 1'b1; req_wdata = 64'hBAD0_BAD0_BAD0_BAD0;
    step(n);
    req_valid = 1'b0;
    chk(overrun_err == 1'b1, "R7 overrun flagged", W'(overrun_err), 1);
    req_valid = 1'b1; req_write = 1'b0;
    step(n);
    req_valid = 1'b0;
    chk(rd_valid == 1'b0, "R7 ignored read no pulse", W'(rd_valid), 0);
    chk(word_idx == 3'(exp_idx), "R7 word_idx unchanged", W'(word_idx), W'(exp_idx));
    while (busy && n < 200) step(n);
    chk(n == W, "R7 burst not extended", W'(n), W'(W));
    for (int j = 0; j < NW; j++) access(1'b0, '0, "R7 ring unaffected by ignored write");
    chk(overrun_err == 1'b1, "R8 sticky after accesses", W'(overrun_err), 1);

    // R3 random mix against word-rotation model
    for (int i = 0; i < 48; i++) begin
      bit wr;
      wr = ($urandom % 2) == 1;
      access(wr, {$urandom, $urandom}, "R3 random read vs ring model");
    end
    chk(overrun_err == 1'b1, "R8 sticky after random", W'(overrun_err), 1);

    // R8 cleared only by reset
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    model_clear();
    chk(overrun_err == 1'b0, "R8 cleared by reset", W'(overrun_err), 0);
    chk(word_idx == 3'd0, "R1 word_idx after reset", W'(word_idx), 0);
    access(1'b0, '0, "R1 ring cleared by reset");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule